// File: doc/BRIEF.md
# Handshaked Register Slave for an Asynchronous System Bus

This block is a small memory-mapped register bank that sits on an asynchronous, wired-OR system bus with an 18-bit address and a 16-bit data path. There is no bus clock. A master places address, cycle type and (for writes) data on the bus, then raises a master strobe. The slave answers with a slave acknowledge once it has produced read data or captured write data. It holds that acknowledge until the master withdraws its strobe. Because the slave paces each transfer, fast and slow devices can share one bus.

A two-bit cycle type selects one of four transfers: word read, read-with-pause (the first half of a read-modify-write), word write and byte write. A read-with-pause raises a lock flag, and the flag stays up until a write completes the sequence. The register window lies inside the device region at the top 8K words of the address space. An access outside the window gets no acknowledge, so the master times out.

A bus-init line returns the slave to its idle, cleared state. Two power-warning lines stop register writes while either one is asserted. Every asynchronous control input passes through a two-flop synchronizer before the local clock domain uses it.

Top module: `async_reg_slave`

## Requirements
- R1: Only addresses whose bits 17:4 equal those of BASE_ADDR (default 18'h3FF00, eight words) are acknowledged. Any other address never raises sSync while mSync is held.
- R2: Cycle code 2'b10 writes all 16 bits of dataIn to the addressed word. Cycle code 2'b00 returns that word on dataOut. The word index is address bits 3:1.
- R3: Cycle code 2'b11 is a byte write. Address bit 0 = 0 updates bits 7:0 from dataIn[7:0]. Address bit 0 = 1 updates bits 15:8 from dataIn[15:8]. The other byte is unchanged.
- R4: Cycle code 2'b01 returns the word like a read and sets rmwLock. rmwLock stays set across plain reads and is cleared by the next acknowledged write of either kind.
- R5: sSync rises only after mSync has been seen high. It stays high for as long as mSync is held and falls after mSync is dropped.
- R6: dataOut carries the read word only while a read or read-with-pause is being acknowledged. Otherwise it is all zeros and dataOe is low.
- R7: While busInit is asserted, the slave returns to idle: sSync low, rmwLock clear and all registers zero.
- R8: While acLow or dcLow is asserted, write cycles are still acknowledged but leave every register unchanged.
- R9: After rstN is released, sSync, dataOe and rmwLock are low, dataOut is zero and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rstN | input | 1 | Active-low local reset |
| busInit | input | 1 | Bus initialise, asynchronous |
| acLow | input | 1 | AC power warning, asynchronous |
| dcLow | input | 1 | DC power warning, asynchronous |
| mSync | input | 1 | Master strobe, asynchronous |
| addr | input | 18 | Bus address (byte granular) |
| ctl | input | 2 | Cycle type code |
| dataIn | input | 16 | Write data from master |
| sSync | output | 1 | Slave acknowledge |
| dataOut | output | 16 | Read data, zero when not driving |
| dataOe | output | 1 | High while read data is driven |
| rmwLock | output | 1 | Read-modify-write in progress |

## Verification
The embedded assertions check four properties on every cycle. An out-of-window strobe never produces an acknowledge. An acknowledge never rises without a prior strobe. Read data is never enabled outside an acknowledge. A write that completes an RMW drops the lock. The same checks cover two further cases: no write strobe reaches the register file during a power warning, and bus-init empties the read latch. Only the scripted scenarios can show the stored values and byte merging, the persistence of the lock across unrelated reads, and the zeroed contents after bus-init. They also show that a write made during a power warning really left the old data in place.

// File: rtl/regslv_pkg.sv
package regslv_pkg;
  localparam int ADDR_W = 18;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    CYC_READ  = 2'b00,
    CYC_RDPS  = 2'b01,
    CYC_WORD  = 2'b10,
    CYC_BYTE  = 2'b11
  } cycle_e;

  typedef struct packed {
    logic       rdLoad;
    logic       wrEn;
    logic       byteWr;
    logic       byteHi;
    logic [7:0] idx;
  } strobe_t;
endpackage

// File: rtl/regslv_sync.sv
module regslv_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/regslv_ctrl.sv
module regslv_ctrl
  import regslv_pkg::*;
#(
  parameter int            IDX_W     = 3,
  parameter logic [17:0]   BASE_ADDR = 18'h3FF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mSyncS,
  input  logic              initS,
  input  logic              pwrFail,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        ctl,
  output strobe_t           strb,
  output logic              sSync,
  output logic              dataOe,
  output logic              rmwLock
);
  localparam int TAG_LO = IDX_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_ACK, ST_SKIP} state_e;
  state_e state;

  logic hit, go, isWrite;
  assign hit     = (addr[ADDR_W-1:TAG_LO] == BASE_ADDR[ADDR_W-1:TAG_LO]);
  assign go      = (state == ST_IDLE) && mSyncS && hit;
  assign isWrite = ctl[1];

  always_comb begin
    strb        = '0;
    strb.rdLoad = go && !isWrite;
    strb.wrEn   = go && isWrite && !pwrFail;
    strb.byteWr = (ctl == CYC_BYTE);
    strb.byteHi = addr[0];
    strb.idx    = 8'(addr[IDX_W:1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sSync   <= 1'b0;
      dataOe  <= 1'b0;
      rmwLock <= 1'b0;
    end else if (initS) begin
      state   <= ST_IDLE;
      sSync   <= 1'b0;
      dataOe  <= 1'b0;
      rmwLock <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (mSyncS) begin
          if (hit) begin
            state  <= ST_ACK;
            sSync  <= 1'b1;
            dataOe <= !isWrite;
            if (ctl == CYC_RDPS) rmwLock <= 1'b1;
            if (isWrite)         rmwLock <= 1'b0;
          end else begin
            state <= ST_SKIP;
          end
        end
        ST_ACK: if (!mSyncS) begin
          state  <= ST_IDLE;
          sSync  <= 1'b0;
          dataOe <= 1'b0;
        end
        ST_SKIP: if (!mSyncS) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  miss_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && mSyncS && !hit) |=> !sSync);

  // R5
  ack_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sSync) |-> $past(mSyncS));

  // R6
  oe_within_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> sSync);

  // R4
  lock_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (go && isWrite && !initS) |=> !rmwLock);
endmodule

// File: rtl/regslv_dpath.sv
module regslv_dpath
  import regslv_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initS,
  input  logic              blockWr,
  input  strobe_t           strb,
  input  logic              dataOe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] rdReg;
  logic [NBYTES-1:0] laneEn;

  always_comb begin
    for (int b = 0; b < NBYTES; b++)
      laneEn[b] = !strb.byteWr || (b == int'(strb.byteHi));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) regFile[r] <= '0;
      rdReg <= '0;
    end else if (initS) begin
      for (int r = 0; r < NUM_REGS; r++) regFile[r] <= '0;
      rdReg <= '0;
    end else begin
      if (strb.rdLoad) rdReg <= regFile[strb.idx];
      if (strb.wrEn) begin
        for (int b = 0; b < NBYTES; b++)
          if (laneEn[b]) regFile[strb.idx][b*8 +: 8] <= dataIn[b*8 +: 8];
      end
    end
  end

  assign dataOut = dataOe ? rdReg : '0;

  // R8
  no_pwrfail_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockWr |-> !strb.wrEn);

  // R7
  init_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    initS |=> (rdReg == '0));
endmodule

// File: rtl/async_reg_slave.sv
module async_reg_slave
  import regslv_pkg::*;
#(
  parameter int          NUM_REGS  = 8,
  parameter logic [17:0] BASE_ADDR = 18'h3FF00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busInit,
  input  logic        acLow,
  input  logic        dcLow,
  input  logic        mSync,
  input  logic [17:0] addr,
  input  logic [1:0]  ctl,
  input  logic [15:0] dataIn,
  output logic        sSync,
  output logic [15:0] dataOut,
  output logic        dataOe,
  output logic        rmwLock
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [3:0] syncd;
  logic       mSyncS, initS, pwrFail;
  strobe_t    strb;

  regslv_sync #(.WIDTH(4), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({dcLow, acLow, busInit, mSync}),
    .syncOut(syncd)
  );

  assign mSyncS  = syncd[0];
  assign initS   = syncd[1];
  assign pwrFail = syncd[2] | syncd[3];

  regslv_ctrl #(.IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .mSyncS(mSyncS), .initS(initS),
    .pwrFail(pwrFail), .addr(addr), .ctl(ctl), .strb(strb),
    .sSync(sSync), .dataOe(dataOe), .rmwLock(rmwLock)
  );

  regslv_dpath #(.NUM_REGS(NUM_REGS)) u_dpath (
    .clk(clk), .rstN(rstN), .initS(initS), .blockWr(pwrFail),
    .strb(strb), .dataOe(dataOe), .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: tb/test_async_reg_slave.sv
module test_async_reg_slave;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busInit = 1'b0, acLow = 1'b0, dcLow = 1'b0, mSync = 1'b0;
  logic [17:0] addr = '0;
  logic [1:0]  ctl = '0;
  logic [15:0] dataIn = '0;
  logic        sSync, dataOe, rmwLock;
  logic [15:0] dataOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  async_reg_slave i_async_reg_slave (
    .clk(clk), .rstN(rstN), .busInit(busInit), .acLow(acLow), .dcLow(dcLow),
    .mSync(mSync), .addr(addr), .ctl(ctl), .dataIn(dataIn),
    .sSync(sSync), .dataOut(dataOut), .dataOe(dataOe), .rmwLock(rmwLock)
  );

  // {ctl, addr, wdata, expRead, expAck, expLock}
  localparam int NV = 14;
  localparam logic [53:0] VEC [NV] = '{
    {2'b10, 18'h3FF00, 16'h1234, 16'h0000, 1'b1, 1'b0}, // R2 word write
    {2'b00, 18'h3FF00, 16'h0000, 16'h1234, 1'b1, 1'b0}, // R2 read back
    {2'b10, 18'h3FF02, 16'hABCD, 16'h0000, 1'b1, 1'b0},
    {2'b11, 18'h3FF02, 16'hEE55, 16'h0000, 1'b1, 1'b0}, // R3 low byte
    {2'b00, 18'h3FF02, 16'h0000, 16'hAB55, 1'b1, 1'b0},
    {2'b11, 18'h3FF03, 16'h6677, 16'h0000, 1'b1, 1'b0}, // R3 high byte
    {2'b00, 18'h3FF03, 16'h0000, 16'h6655, 1'b1, 1'b0},
    {2'b01, 18'h3FF00, 16'h0000, 16'h1234, 1'b1, 1'b1}, // R4 lock set
    {2'b00, 18'h3FF02, 16'h0000, 16'h6655, 1'b1, 1'b1}, // R4 lock kept
    {2'b10, 18'h3FF00, 16'h5678, 16'h0000, 1'b1, 1'b0}, // R4 lock cleared
    {2'b00, 18'h3FF00, 16'h0000, 16'h5678, 1'b1, 1'b0},
    {2'b00, 18'h3FE00, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R1 miss
    {2'b10, 18'h3FF0E, 16'hFFFF, 16'h0000, 1'b1, 1'b0}, // R1 top word
    {2'b00, 18'h3FF0E, 16'h0000, 16'hFFFF, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busCycle(input logic [1:0] c, input logic [17:0] a,
                          input logic [15:0] w, output logic ack,
                          output logic [15:0] rd);
    @(negedge clk);
    ctl = c; addr = a; dataIn = w; mSync = 1'b1;
    ack = 1'b0; rd = '0;
    for (int i = 0; i < 12 && !ack; i++) begin
      @(negedge clk);
      if (sSync) begin ack = 1'b1; rd = dataOut; end
    end
    if (ack) begin
      repeat (3) @(negedge clk);
      chk(sSync === 1'b1, "R5 hold while strobe", sSync, 1);
    end
    mSync = 1'b0;
    for (int i = 0; i < 12 && sSync; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(sSync === 1'b0, "R5 release", sSync, 0);
    chk(dataOut === 16'h0 && dataOe === 1'b0, "R6 idle bus quiet", dataOut, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic ack;
    logic [15:0] rd;
    logic [53:0] v;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(sSync === 1'b0, "R9 sSync", sSync, 0);
    chk(dataOe === 1'b0 && dataOut === 16'h0, "R9 dataOut", dataOut, 0);
    chk(rmwLock === 1'b0, "R9 lock", rmwLock, 0);
    busCycle(2'b00, 18'h3FF04, 16'h0, ack, rd);
    chk(ack && rd === 16'h0, "R9 register zero", rd, 0);

    for (int n = 0; n < NV; n++) begin
      v = VEC[n];
      busCycle(v[53:52], v[51:34], v[33:18], ack, rd);
      chk(ack === v[1], $sformatf("R1 ack vector %0d", n), ack, v[1]);
      if (!v[53] && v[1])
        chk(rd === v[17:2], $sformatf("R2 read data vector %0d", n), rd, v[17:2]);
      chk(rmwLock === v[0], $sformatf("R4 lock vector %0d", n), rmwLock, v[0]);
    end

    // R6: byte-write code never drives read data
    busCycle(2'b11, 18'h3FF0C, 16'h00AA, ack, rd);
    chk(ack && rd === 16'h0, "R6 no data on write", rd, 0);

    // R8 power warnings block writes
    acLow = 1'b1;
    repeat (4) @(negedge clk);
    busCycle(2'b10, 18'h3FF00, 16'h1111, ack, rd);
    chk(ack === 1'b1, "R8 write acked under acLow", ack, 1);
    acLow = 1'b0; dcLow = 1'b1;
    repeat (4) @(negedge clk);
    busCycle(2'b11, 18'h3FF01, 16'h2200, ack, rd);
    dcLow = 1'b0;
    repeat (4) @(negedge clk);
    busCycle(2'b00, 18'h3FF00, 16'h0, ack, rd);
    chk(rd === 16'h5678, "R8 register unchanged", rd, 16'h5678);

    // R7 bus init
    busCycle(2'b01, 18'h3FF02, 16'h0, ack, rd);
    chk(rmwLock === 1'b1, "R7 lock before init", rmwLock, 1);
    busInit = 1'b1;
    repeat (5) @(negedge clk);
    busInit = 1'b0;
    repeat (3) @(negedge clk);
    chk(rmwLock === 1'b0 && sSync === 1'b0, "R7 lock cleared", rmwLock, 0);
    busCycle(2'b00, 18'h3FF00, 16'h0, ack, rd);
    chk(rd === 16'h0, "R7 register cleared", rd, 0);
    busCycle(2'b00, 18'h3FF0E, 16'h0, ack, rd);
    chk(rd === 16'h0, "R7 top register cleared", rd, 0);

    finishRun();
  end
endmodule